// File: doc/BRIEF.md
# Delay-Slot Next-PC Sequencer

This block holds the two program counters of a 32-bit processor whose control transfers take effect one instruction late: `pc`, the address of the instruction now executing, and `npc`, the address of the one after it. Each advance moves `npc` into `pc` and computes a fresh `npc`. A branch or jump therefore changes `npc` and not `pc`, so exactly one delay-slot instruction runs after every taken transfer.

Each cycle the decode stage presents a transfer kind, a 16-bit branch offset, a 26-bit jump target, a register value for indirect jumps and two comparison operands. When `adv` is high the sequencer steps. Linking transfers also raise a one-cycle write request for the link register, carrying the return address. Fetch, decode and exceptions belong to other blocks.

Top module: `dsn_seq`

## Requirements
- R1: While `rst` is high, the next clock edge sets `pc` to `START_ADDR`, `npc` to `START_ADDR`+4 and `link_we` to 0.
- R2: On a clock edge with `adv` low, `pc` and `npc` keep their values and `link_we` is 0 after that edge, whatever the kind.
- R3: On every clock edge with `adv` high, the new `pc` equals the previous `npc`.
- R4: Kind 0 (sequential), and the unused codes 12 to 15, set the new `npc` to the previous `npc`+4.
- R5: Branch kinds compare signed values: 1 taken when `op_a`==`op_b`, 2 when `op_a`!=`op_b`, 3 and 7 when `op_a`>=0, 4 when `op_a`>0, 5 when `op_a`<=0, 6 and 8 when `op_a`<0. A taken branch sets `npc` to the previous `npc` plus `br_off`, sign-extended and shifted left by two. An untaken branch adds 4.
- R6: Kinds 9 (jump) and 10 (jump and link) set `npc` to the top 4 bits of the previous `npc` followed by `jmp_tgt` and two zero bits.
- R7: Kind 11 (indirect jump) loads `npc` with `ind_addr` exactly, low bits included.
- R8: After an advance of kind 10, or of kind 7 or 8 with the branch taken, `link_we` is 1 for one cycle and `link_val` equals the previous `npc`+4. `link_idx` is always 31.
- R9: After an advance of any other kind, or of kind 7 or 8 not taken, `link_we` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| adv | input | 1 | Step strobe |
| kind | input | 4 | Transfer kind code |
| br_off | input | 16 | Branch offset in words |
| jmp_tgt | input | 26 | Direct jump target in words |
| ind_addr | input | 32 | Register value for indirect jump |
| op_a | input | 32 | First comparison operand |
| op_b | input | 32 | Second comparison operand |
| pc | output | 32 | Current instruction address |
| npc | output | 32 | Next instruction address |
| link_we | output | 1 | Link register write request |
| link_val | output | 32 | Return address to write |
| link_idx | output | 5 | Link register index |

## Verification
The bench builds the block with `START_ADDR` set to 32'hEFFF_FF00, close to a 256 MB region boundary, so sequential flow and negative branches cross the top-nibble change that direct jumps inherit from `npc`. It sweeps all sixteen kind codes against five signed operand values (zero, one, minus one, largest and smallest) in equal and unequal pairs and four offsets including both 16-bit extremes. Hold cycles with branch and link kinds present are interleaved.

// File: rtl/dsn_pkg.sv
package dsn_pkg;
  typedef enum logic [3:0] {
    XF_SEQ    = 4'd0,
    XF_BEQ    = 4'd1,
    XF_BNE    = 4'd2,
    XF_BGEZ   = 4'd3,
    XF_BGTZ   = 4'd4,
    XF_BLEZ   = 4'd5,
    XF_BLTZ   = 4'd6,
    XF_BGEZL  = 4'd7,
    XF_BLTZL  = 4'd8,
    XF_JMP    = 4'd9,
    XF_JMPL   = 4'd10,
    XF_JIND   = 4'd11
  } xfer_e;

  localparam int KIND_W = 4;
endpackage

// File: rtl/dsn_cond.sv
module dsn_cond
  import dsn_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  xfer_e             kind,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  output logic              is_br,
  output logic              taken
);
  logic a_neg, a_zero, a_eq_b;

  assign a_neg  = op_a[DATA_W-1];
  assign a_zero = (op_a == '0);
  assign a_eq_b = (op_a == op_b);

  always_comb begin
    is_br = 1'b1;
    taken = 1'b0;
    unique case (kind)
      XF_BEQ:            taken = a_eq_b;
      XF_BNE:            taken = !a_eq_b;
      XF_BGEZ, XF_BGEZL: taken = !a_neg;
      XF_BGTZ:           taken = !a_neg && !a_zero;
      XF_BLEZ:           taken = a_neg || a_zero;
      XF_BLTZ, XF_BLTZL: taken = a_neg;
      default:           is_br = 1'b0;
    endcase
  end
endmodule

// File: rtl/dsn_target.sv
module dsn_target
  import dsn_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16,
  parameter int TGT_W  = 26
) (
  input  xfer_e             kind,
  input  logic              is_br,
  input  logic              taken,
  input  logic [ADDR_W-1:0] npc_cur,
  input  logic [OFF_W-1:0]  br_off,
  input  logic [TGT_W-1:0]  jmp_tgt,
  input  logic [ADDR_W-1:0] ind_addr,
  output logic [ADDR_W-1:0] npc_nxt,
  output logic              link_req
);
  localparam int REGION_W = ADDR_W - TGT_W - 2;
  localparam int EXT_W    = ADDR_W - OFF_W - 2;

  logic [ADDR_W-1:0] seq_addr, br_step, br_addr, jmp_addr;

  assign seq_addr = npc_cur + ADDR_W'(4);
  assign br_step  = {{EXT_W{br_off[OFF_W-1]}}, br_off, 2'b00};
  assign br_addr  = npc_cur + br_step;
  assign jmp_addr = {npc_cur[ADDR_W-1 -: REGION_W], jmp_tgt, 2'b00};

  always_comb begin
    if (is_br) begin
      npc_nxt = taken ? br_addr : seq_addr;
    end else begin
      unique case (kind)
        XF_JMP, XF_JMPL: npc_nxt = jmp_addr;
        XF_JIND:         npc_nxt = ind_addr;
        default:         npc_nxt = seq_addr;
      endcase
    end
  end

  always_comb begin
    unique case (kind)
      XF_JMPL:           link_req = 1'b1;
      XF_BGEZL, XF_BLTZL: link_req = taken;
      default:           link_req = 1'b0;
    endcase
  end
endmodule

// File: rtl/dsn_seq.sv
module dsn_seq
  import dsn_pkg::*;
#(
  parameter int              ADDR_W     = 32,
  parameter int              OFF_W      = 16,
  parameter int              TGT_W      = 26,
  parameter int              REG_W      = 5,
  parameter int              LINK_REG   = 31,
  parameter logic [ADDR_W-1:0] START_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  input  logic [KIND_W-1:0] kind,
  input  logic [OFF_W-1:0]  br_off,
  input  logic [TGT_W-1:0]  jmp_tgt,
  input  logic [ADDR_W-1:0] ind_addr,
  input  logic [ADDR_W-1:0] op_a,
  input  logic [ADDR_W-1:0] op_b,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] npc,
  output logic              link_we,
  output logic [ADDR_W-1:0] link_val,
  output logic [REG_W-1:0]  link_idx
);
  xfer_e             kind_e;
  logic              is_br, taken, link_req;
  logic [ADDR_W-1:0] npc_nxt;

  assign kind_e   = xfer_e'(kind);
  assign link_idx = REG_W'(LINK_REG);

  dsn_cond #(.DATA_W(ADDR_W)) cond_i (
    .kind  (kind_e),
    .op_a  (op_a),
    .op_b  (op_b),
    .is_br (is_br),
    .taken (taken)
  );

  dsn_target #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .TGT_W(TGT_W)) tgt_i (
    .kind     (kind_e),
    .is_br    (is_br),
    .taken    (taken),
    .npc_cur  (npc),
    .br_off   (br_off),
    .jmp_tgt  (jmp_tgt),
    .ind_addr (ind_addr),
    .npc_nxt  (npc_nxt),
    .link_req (link_req)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc       <= START_ADDR;
      npc      <= START_ADDR + ADDR_W'(4);
      link_we  <= 1'b0;
      link_val <= '0;
    end else begin
      link_we <= adv && link_req;
      if (adv) begin
        pc  <= npc;
        npc <= npc_nxt;
        if (link_req) link_val <= npc + ADDR_W'(4);
      end
    end
  end
endmodule

// File: rtl/dsn_seq_chk.sv
module dsn_seq_chk #(
  parameter int                ADDR_W     = 32,
  parameter logic [ADDR_W-1:0] START_ADDR = '0
) (
  input logic              clk,
  input logic              rst,
  input logic              adv,
  input logic [3:0]        kind,
  input logic [ADDR_W-1:0] pc,
  input logic [ADDR_W-1:0] npc,
  input logic              link_we,
  input logic [ADDR_W-1:0] link_val
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (pc == START_ADDR) && (npc == START_ADDR + ADDR_W'(4)) && !link_we);

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(pc) && $stable(npc) && !link_we);

  // R3
  pc_follow_chk: assert property (@(posedge clk) disable iff (rst)
    adv |=> pc == $past(npc));

  // R4
  seq_step_chk: assert property (@(posedge clk) disable iff (rst)
    (adv && (kind == 4'd0 || kind >= 4'd12)) |=> npc == $past(npc) + ADDR_W'(4));

  // R6
  jump_region_chk: assert property (@(posedge clk) disable iff (rst)
    (adv && (kind == 4'd9 || kind == 4'd10)) |=>
      (npc[ADDR_W-1 -: 4] == pc[ADDR_W-1 -: 4]) && (npc[1:0] == 2'b00));

  // R8
  link_value_chk: assert property (@(posedge clk) disable iff (rst)
    link_we |-> link_val == pc + ADDR_W'(4));

  // R8
  jal_link_chk: assert property (@(posedge clk) disable iff (rst)
    (adv && kind == 4'd10) |=> link_we);

  // R9
  no_link_chk: assert property (@(posedge clk) disable iff (rst)
    (adv && !(kind == 4'd7 || kind == 4'd8 || kind == 4'd10)) |=> !link_we);
endmodule

bind dsn_seq dsn_seq_chk #(.ADDR_W(ADDR_W), .START_ADDR(START_ADDR)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .adv      (adv),
  .kind     (kind),
  .pc       (pc),
  .npc      (npc),
  .link_we  (link_we),
  .link_val (link_val)
);

// File: tb/dsn_seq_tb.sv
module dsn_seq_tb_top;
  localparam logic [31:0] START = 32'hEFFF_FF00;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        adv = 1'b0;
  logic [3:0]  kind = '0;
  logic [15:0] br_off = '0;
  logic [25:0] jmp_tgt = '0;
  logic [31:0] ind_addr = '0;
  logic [31:0] op_a = '0;
  logic [31:0] op_b = '0;
  logic [31:0] pc, npc, link_val;
  logic        link_we;
  logic [4:0]  link_idx;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] m_pc, m_npc;

  always #10 clk = ~clk;

  dsn_seq #(.START_ADDR(START)) dut_i (
    .clk(clk), .rst(rst), .adv(adv), .kind(kind), .br_off(br_off),
    .jmp_tgt(jmp_tgt), .ind_addr(ind_addr), .op_a(op_a), .op_b(op_b),
    .pc(pc), .npc(npc), .link_we(link_we), .link_val(link_val),
    .link_idx(link_idx)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic cond_of(input logic [3:0] k, input logic [31:0] a, input logic [31:0] b);
    case (k)
      4'd1: return a == b;
      4'd2: return a != b;
      4'd3, 4'd7: return $signed(a) >= 0;
      4'd4: return $signed(a) > 0;
      4'd5: return $signed(a) <= 0;
      4'd6, 4'd8: return $signed(a) < 0;
      default: return 1'b0;
    endcase
  endfunction

  task automatic step(input logic [3:0] k, input logic [31:0] a, input logic [31:0] b,
                      input logic [15:0] off, input logic [25:0] tg, input logic [31:0] ia);
    logic [31:0] e_npc;
    logic        e_lw;
    logic        tk;
    kind = k; op_a = a; op_b = b; br_off = off; jmp_tgt = tg; ind_addr = ia; adv = 1'b1;
    tk = cond_of(k, a, b);
    e_lw = (k == 4'd10) || ((k == 4'd7 || k == 4'd8) && tk);
    if (k >= 4'd1 && k <= 4'd8)
      e_npc = tk ? m_npc + {{14{off[15]}}, off, 2'b00} : m_npc + 32'd4;
    else if (k == 4'd9 || k == 4'd10)
      e_npc = {m_npc[31:28], tg, 2'b00};
    else if (k == 4'd11)
      e_npc = ia;
    else
      e_npc = m_npc + 32'd4;
    @(negedge clk);
    check("R3 pc", pc, m_npc);
    if (k >= 4'd1 && k <= 4'd8) check("R5 npc", npc, e_npc);
    else if (k == 4'd9 || k == 4'd10) check("R6 npc", npc, e_npc);
    else if (k == 4'd11) check("R7 npc", npc, e_npc);
    else check("R4 npc", npc, e_npc);
    if (e_lw) begin
      check("R8 link_we", {31'd0, link_we}, 32'd1);
      check("R8 link_val", link_val, m_npc + 32'd4);
    end else begin
      check("R9 link_we", {31'd0, link_we}, 32'd0);
    end
    m_pc = m_npc;
    m_npc = e_npc;
  endtask

  task automatic hold(input logic [3:0] k);
    kind = k; op_a = 32'hFFFF_FFFF; op_b = 32'hFFFF_FFFF; br_off = 16'h0010; adv = 1'b0;
    @(negedge clk);
    check("R2 pc", pc, m_pc);
    check("R2 npc", npc, m_npc);
    check("R2 link_we", {31'd0, link_we}, 32'd0);
  endtask

  initial begin
    #4_000_000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] vals [5];
    logic [15:0] offs [4];
    vals[0] = 32'd0; vals[1] = 32'd1; vals[2] = 32'hFFFF_FFFF;
    vals[3] = 32'h7FFF_FFFF; vals[4] = 32'h8000_0000;
    offs[0] = 16'h0000; offs[1] = 16'h0003; offs[2] = 16'h8000; offs[3] = 16'h7FFF;

    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    check("R1 pc", pc, START);
    check("R1 npc", npc, START + 32'd4);
    check("R1 link_we", {31'd0, link_we}, 32'd0);
    check("R8 link_idx", {27'd0, link_idx}, 32'd31);
    m_pc = START; m_npc = START + 32'd4;

    for (int s = 0; s < 70; s++) step(4'd0, 32'd0, 32'd0, 16'd0, 26'd0, 32'd0);

    for (int k = 0; k < 16; k++) begin
      for (int v = 0; v < 5; v++) begin
        for (int e = 0; e < 2; e++) begin
          for (int o = 0; o < 4; o++) begin
            step(4'(k), vals[v], (e == 0) ? vals[v] : (vals[v] ^ 32'h1), offs[o],
                 26'(32'h02A5_5A5 * (o + 1) + v), 32'h1234_5673 ^ 32'(k * 77 + o));
          end
          hold(4'(7 + (v % 2)));
        end
      end
      hold(4'd10);
    end

    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 pc", pc, START);
    check("R1 npc", npc, START + 32'd4);
    check("R1 link_we", {31'd0, link_we}, 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule